// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a register-mapped master for a Clause 45 management bus. A host reaches PHY registers through four 32-bit words: a configuration/status word, a control word, a data word and an address word. Three kinds of transaction exist, and each is started by a write to a different word. Writing the address word sends an address frame. Writing the data word sends a write frame. Writing the control word with its read bit set sends a read frame, and the 16-bit reply is then held in the data word.

The block generates the management clock from a programmable divider. The bidirectional data line is split into an output, an output enable and an input, so the pad can sit outside the block. The status word shows whether any frame is in progress. Bit 31 of the data word shows, separately, whether a write or read frame is still running. A read that gets no answer from a PHY during turnaround raises an error flag.

Top module: `mdio45_master`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, holds `mdc` low and deasserts `mdio_oe`.
- R2: The byte offsets are status 0x30, control 0x34, data 0x38 and address 0x3C. Any other offset reads as zero. Control reads back as bit 10 (no preamble), bits 9:5 (port), bits 4:0 (device) and reads bit 15 as 0. Status bits 15:8 read back the divider.
- R3: A write to the address word (low 16 bits) starts an address frame using the stored port and device. Status bit 0 reads 1 until that frame ends, and data bit 31 stays 0 during it.
- R4: A write to the data word (low 16 bits) starts a write frame. Data bit 31 and status bit 0 both read 1 until that frame ends.
- R5: A control write with bit 15 set starts a read frame using the port and device carried in that same write. Data bit 31 reads 1 until the frame ends, after which data bits 15:0 hold the 16 bits sampled from the line.
- R6: A frame is sent MSB first in this order: 32 ones of preamble, start 00, a 2-bit opcode (00 address, 01 write, 11 read), 5-bit port, 5-bit device, turnaround 10 (driven only in non-read frames), then 16 data bits.
- R7: With control bit 10 set, the preamble is left out and the frame is 32 bits long.
- R8: `mdc` idles low and toggles only during a frame. Each half-period is (status bits 15:8) + 1 system clocks. `mdio_o` changes only while `mdc` is low, and the line is sampled on the rising edge. `mdio_oe` is low whenever no frame is active.
- R9: In a read, `mdio_oe` drops for the turnaround and data bits. If a 1 is sampled on the second turnaround bit, status bit 1 is set, and with the line pulled high the data word reads 0xFFFF.
- R10: Status bit 1 is cleared when the next read frame is launched.
- R11: While a frame is in progress, every register write is ignored. No new frame starts and the stored values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is returned one cycle later |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A wrong bit counter or a wrong shift register shows up in the next frame as a misplaced opcode, address or turnaround field. The PHY model decodes every frame bit by bit as it goes by. A divider fault changes the `mdc` half-period in the first bit of a frame. A busy flag that clears early or late is seen by the host poll within a few reads: the data word holds the wrong value, or an ignored write leaks into a stored register. A flag that fails to clear or to set in a read is visible in the status word right after launch and right after completion.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;

  localparam int unsigned OFF_STAT = 'h30;
  localparam int unsigned OFF_CTL  = 'h34;
  localparam int unsigned OFF_DATA = 'h38;
  localparam int unsigned OFF_ADDR = 'h3C;

  localparam int unsigned DIV_W  = 8;
  localparam int unsigned PHY_W  = 5;
  localparam int unsigned WORD_W = 16;
endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             mdc_q;
  logic             hit;

  assign hit = en && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = hit && !mdc_q;
  assign fall_tick = hit && mdc_q;
endmodule

// File: rtl/mdio45_frame.sv
module mdio45_frame
  import mdio45_pkg::*;
#(
  parameter int unsigned PRE_W  = 32,
  parameter int unsigned ADR_W  = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_op_e          op,
  input  logic [ADR_W-1:0]  port,
  input  logic [ADR_W-1:0]  dev,
  input  logic [DATA_W-1:0] wdata,
  input  logic              no_pre,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output mdio_op_e          cur_op,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              ta_err,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned BODY_W  = 2 + 2 + 2 * ADR_W + 2 + DATA_W;
  localparam int unsigned FRAME_W = PRE_W + BODY_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] IDX_TA2  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] IDX_REL  = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_PRE = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_NOP = CNT_W'(BODY_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   idx_q;
  logic [DATA_W-1:0]  rx_q;
  logic               busy_q, oe_q;
  mdio_op_e           op_q;
  logic               is_rd;

  assign frame = {{PRE_W{1'b1}}, 2'b00, op, port, dev, 2'b10, wdata};
  assign is_rd = (op_q == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      oe_q   <= 1'b0;
      op_q   <= OP_ADDR;
      rx_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        oe_q   <= 1'b1;
        op_q   <= op;
        sh_q   <= no_pre ? (frame << PRE_W) : frame;
        idx_q  <= no_pre ? LAST_NOP : LAST_PRE;
      end
    end else begin
      if (rise_tick && is_rd && idx_q < IDX_TA2)
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == '0) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          idx_q <= idx_q - 1'b1;
          sh_q  <= sh_q << 1;
          if (is_rd && idx_q == IDX_REL) oe_q <= 1'b0;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign cur_op  = op_q;
  assign mdio_o  = sh_q[FRAME_W-1];
  assign mdio_oe = oe_q;
  assign done    = busy_q && fall_tick && (idx_q == '0);
  assign ta_err  = busy_q && rise_tick && is_rd && (idx_q == IDX_TA2) && mdio_i;
  assign rdata   = rx_q;
endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
  import mdio45_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(OFF_ADDR);

  logic [DIV_W-1:0]  div_q;
  logic [PHY_W-1:0]  port_q, dev_q;
  logic              nopre_q;
  logic [WORD_W-1:0] addr_q, data_q;
  logic              rd_err_q;
  logic [31:0]       rdata_q;

  logic              eng_busy, eng_is_rd, eng_done, eng_ta_err;
  mdio_op_e          eng_op;
  logic [WORD_W-1:0] eng_rdata;
  logic              rise_tick, fall_tick;

  logic     wr_ok, st_addr, st_wr, st_rd, start;
  mdio_op_e start_op;
  logic [PHY_W-1:0] f_port, f_dev;

  assign wr_ok   = reg_wr && !eng_busy;
  assign st_addr = wr_ok && (reg_addr == A_ADDR);
  assign st_wr   = wr_ok && (reg_addr == A_DATA);
  assign st_rd   = wr_ok && (reg_addr == A_CTL) && reg_wdata[15];
  assign start   = st_addr || st_wr || st_rd;
  assign start_op = st_rd ? OP_READ : (st_wr ? OP_WRITE : OP_ADDR);
  assign f_port  = st_rd ? reg_wdata[9:5] : port_q;
  assign f_dev   = st_rd ? reg_wdata[4:0] : dev_q;
  assign eng_is_rd = (eng_op == OP_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      port_q   <= '0;
      dev_q    <= '0;
      nopre_q  <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      rd_err_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          A_STAT: div_q <= reg_wdata[15:8];
          A_CTL: begin
            dev_q   <= reg_wdata[4:0];
            port_q  <= reg_wdata[9:5];
            nopre_q <= reg_wdata[10];
          end
          A_DATA: data_q <= reg_wdata[15:0];
          A_ADDR: addr_q <= reg_wdata[15:0];
          default: ;
        endcase
      end
      if (eng_done && eng_is_rd) data_q <= eng_rdata;
      if (st_rd) rd_err_q <= 1'b0;
      else if (eng_ta_err) rd_err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_STAT:  rdata_q <= {16'b0, div_q, 6'b0, rd_err_q, eng_busy};
        A_CTL:   rdata_q <= {21'b0, nopre_q, port_q, dev_q};
        A_DATA:  rdata_q <= {eng_busy && (eng_op != OP_ADDR), 15'b0, data_q};
        A_ADDR:  rdata_q <= {16'b0, addr_q};
        default: rdata_q <= '0;
      endcase
    end
  end
  assign reg_rdata = rdata_q;

  mdio45_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .en(eng_busy), .div(div_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio45_frame #(.PRE_W(32), .ADR_W(PHY_W), .DATA_W(WORD_W)) u_frame (
    .clk(clk), .rst(rst), .start(start), .op(start_op),
    .port(f_port), .dev(f_dev), .wdata(reg_wdata[15:0]), .no_pre(nopre_q),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(eng_busy), .cur_op(eng_op), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(eng_done), .ta_err(eng_ta_err), .rdata(eng_rdata)
  );
endmodule

// File: rtl/mdio45_master_chk.sv
module mdio45_master_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_oe,
  input logic mdio_o,
  input logic busy,
  input logic is_rd,
  input logic err
);
  // R8
  mdc_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdc);
  // R8
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !mdio_oe);
  // R8
  drive_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(busy && is_rd));
  // R6
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> busy);
endmodule

bind mdio45_master mdio45_master_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_oe(mdio_oe), .mdio_o(mdio_o),
  .busy(eng_busy), .is_rd(eng_is_rd), .err(rd_err_q)
);

// File: tb/mdio45_master_test.sv
module mdio45_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe;
  logic        phy_bit = 1'b1;
  wire         mdio_i = mdio_oe ? mdio_o : phy_bit;

  int checks = 0, errors = 0;
  bit finished = 0;

  localparam logic [5:0] STAT = 6'h30, CTL = 6'h34, DAT = 6'h38, ADR = 6'h3C;

  typedef struct {
    logic [1:0] op; logic [4:0] port, dev; logic [15:0] data;
    bit nopre; bit respond;
  } frame_t;
  frame_t expq[$];

  mdio45_master uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    s = 32'h1;
    for (int i = 0; i < 5000 && s[0] !== 1'b0; i++) rd(STAT, s);
  endtask

  task automatic push(logic [1:0] op, logic [4:0] p, logic [4:0] dv,
                      logic [15:0] d, bit np, bit resp);
    frame_t f;
    f.op = op; f.port = p; f.dev = dv; f.data = d; f.nopre = np; f.respond = resp;
    expq.push_back(f);
  endtask

  // PHY model and scoreboard monitor
  initial begin
    forever begin
      @(posedge mdio_oe);
      if (expq.size() == 0) begin
        check("R11 unexpected frame", 32'h1, 32'h0);
      end else begin
        frame_t e;
        int n, pre, h;
        logic [63:0] bits;
        logic [1:0] exp_ta;
        logic [15:0] exp_d;
        e = expq.pop_front();
        n = e.nopre ? 32 : 64;
        pre = e.nopre ? 0 : 32;
        bits = '0;
        for (int k = 0; k < n; k++) begin
          @(posedge mdc);
          bits = {bits[62:0], mdio_i};
          if (k < n - 1) begin
            @(negedge mdc);
            h = k + 1 - pre;
            if (e.op == 2'b11 && e.respond && h == 15) phy_bit = 1'b0;
            else if (e.op == 2'b11 && e.respond && h >= 16) phy_bit = e.data[31 - h];
            else phy_bit = 1'b1;
          end
        end
        phy_bit = 1'b1;
        exp_ta = (e.op != 2'b11) ? 2'b10 : (e.respond ? 2'b10 : 2'b11);
        exp_d  = (e.op == 2'b11 && !e.respond) ? 16'hFFFF : e.data;
        if (!e.nopre) check("R6 preamble", bits[63:32], 32'hFFFF_FFFF);
        check(e.nopre ? "R7 start field" : "R6 start field", 32'(bits[31:30]), 32'h0);
        check("R6 opcode", 32'(bits[29:28]), 32'(e.op));
        check("R6 port/device", 32'(bits[27:18]), 32'({e.port, e.dev}));
        check(e.op == 2'b11 ? "R9 turnaround" : "R6 turnaround", 32'(bits[17:16]), 32'(exp_ta));
        check("R6 data bits", 32'(bits[15:0]), 32'(exp_d));
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(STAT, v); check("R1 status", v, 32'h0);
    rd(CTL, v);  check("R1 control", v, 32'h0);
    rd(DAT, v);  check("R1 data", v, 32'h0);
    rd(ADR, v);  check("R1 address", v, 32'h0);
    check("R1 mdc/oe", {30'b0, mdc, mdio_oe}, 32'h0);

    // R2 map
    rd(6'h00, v); check("R2 reserved 0x00", v, 32'h0);
    rd(6'h10, v); check("R2 reserved 0x10", v, 32'h0);
    wr(CTL, 32'h0000_0143); rd(CTL, v); check("R2 control readback", v, 32'h143);
    wr(STAT, 32'h0000_0100); rd(STAT, v); check("R2 divider readback", v, 32'h100);

    // R3 address frame
    push(2'b00, 5'h0A, 5'h03, 16'h1234, 0, 0);
    wr(ADR, 32'h1234);
    rd(STAT, v); check("R3 status busy", 32'(v[0]), 32'h1);
    rd(DAT, v);  check("R3 data busy stays 0", 32'(v[31]), 32'h0);
    wait_idle();
    rd(ADR, v);  check("R3 address held", v, 32'h1234);

    // R4 write frame
    push(2'b01, 5'h0A, 5'h03, 16'hBEEF, 0, 0);
    wr(DAT, 32'hBEEF);
    rd(DAT, v);  check("R4 data busy", v, 32'h8000_BEEF);
    rd(STAT, v); check("R4 status busy", 32'(v[0]), 32'h1);
    wait_idle();
    rd(DAT, v);  check("R4 data after", v, 32'h0000_BEEF);

    // R11 writes ignored while busy
    push(2'b01, 5'h0A, 5'h03, 16'hA5A5, 0, 0);
    wr(DAT, 32'hA5A5);
    wr(DAT, 32'h1234);
    wr(ADR, 32'h5555);
    wr(CTL, 32'h0000_8000);
    wr(STAT, 32'h0000_0500);
    wait_idle();
    rd(DAT, v);  check("R11 data unchanged", v, 32'hA5A5);
    rd(ADR, v);  check("R11 address unchanged", v, 32'h1234);
    rd(CTL, v);  check("R11 control unchanged", v, 32'h143);
    rd(STAT, v); check("R11 divider unchanged", v, 32'h100);

    // R5 read frame with reply
    push(2'b11, 5'h0A, 5'h03, 16'hC0DE, 0, 1);
    wr(CTL, 32'h0000_8143);
    rd(DAT, v);  check("R5 data busy", 32'(v[31]), 32'h1);
    wait_idle();
    rd(DAT, v);  check("R5 read value", v, 32'h0000_C0DE);
    rd(STAT, v); check("R5 no error", 32'(v[1]), 32'h0);
    rd(CTL, v);  check("R2 read bit reads 0", v, 32'h143);

    // R9 read with no responder
    push(2'b11, 5'h0A, 5'h03, 16'h0000, 0, 0);
    wr(CTL, 32'h0000_8143);
    wait_idle();
    rd(STAT, v); check("R9 error flag", 32'(v[1]), 32'h1);
    rd(DAT, v);  check("R9 all ones", v, 32'h0000_FFFF);

    // R10 cleared on next launch
    push(2'b11, 5'h11, 5'h1F, 16'h0042, 0, 1);
    wr(CTL, 32'h0000_823F);
    rd(STAT, v); check("R10 error cleared at launch", 32'(v[1:0]), 32'h1);
    wait_idle();
    rd(DAT, v);  check("R10 read value", v, 32'h0042);

    // R7 preamble disabled
    wr(CTL, 32'h0000_0543);
    push(2'b00, 5'h0A, 5'h03, 16'h0007, 1, 0);
    wr(ADR, 32'h0007);
    wait_idle();
    push(2'b11, 5'h0A, 5'h03, 16'h1357, 1, 1);
    wr(CTL, 32'h0000_8543);
    wait_idle();
    rd(DAT, v);  check("R7 read without preamble", v, 32'h1357);

    // R8 divider and idle level
    wr(STAT, 32'h0000_0200);
    push(2'b01, 5'h0A, 5'h03, 16'h0F0F, 1, 0);
    wr(DAT, 32'h0F0F);
    @(posedge mdc);
    c = 0;
    do begin @(negedge clk); c++; end while (mdc);
    check("R8 high half-period", 32'(c - 1), 32'd3);
    c = 0;
    do begin @(negedge clk); c++; end while (!mdc);
    check("R8 low half-period", 32'(c), 32'd3);
    wait_idle();
    repeat (10) @(negedge clk);
    check("R8 idle low", {30'b0, mdc, mdio_oe}, 32'h0);
    check("R11 all frames seen", 32'(expq.size()), 32'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule